// File: doc/BRIEF.md
# Bus Master Cycle Sequencer

This block owns the bus side of a DMA engine that talks to memory over a 16-bit bus where address and data share the same lines. When the engine presents a word to move, the block pulls an active-low bus request, waits for the arbiter's active-low grant and then runs one transfer cycle per word. Each cycle puts the address on the shared lines under a latch strobe. On a read it releases the lines, waits one turnaround tick and then opens the data strobe. On a write it drives the data from the same point. The cycle closes when the slave answers with an active-low READY.

All timing runs on a tick of one clock period, which stands for 50 ns. A cycle without wait states lasts 12 ticks. Each READY check that finds the slave not ready adds two ticks, so the cycle grows in 100 ns steps. Words in one bus tenure are separated by a single gap tick. The bus is given up after eight words, or earlier when no further word is waiting. The active level of the latch strobe is chosen by an input. Whenever the block does not own the bus, the bus and its control lines are tri-stated through two enables.

Top module: `bus_master_seq`

## Requirements
- R1: During and after reset, `bus_req_n` is 1, `ctl_oe` and `dal_oe` are 0 and `word_done` is 0.
- R2: With `req_valid` high and `bus_gnt_n` high in idle, `bus_req_n` goes low one tick later. `ctl_oe` and `dal_oe` stay 0 until `bus_gnt_n` is sampled low. The first cycle begins (tick 0) on the next tick.
- R3: `bus_req_n` stays low from the request until release, including every cycle and every gap tick between cycles.
- R4: In cycle ticks 0 and 1 the latch strobe is active. In ticks 0 to 3 `dal_oe` is 1 and `dal_out` carries the latched address. The data strobe is never active together with the latch strobe.
- R5: With `as_active_high`=1 the latch strobe `ale` is active high (1 in ticks 0-1, else 0). With `as_active_high`=0 it is active low (0 in ticks 0-1, else 1).
- R6: In a read, `dal_oe` is 0 from tick 4 to the end of the cycle. `das_n` falls at tick 5. `xcvr_rd_n` is 0 from tick 4 to the end of the cycle and 1 at all other times.
- R7: In a write, `dal_out` carries the write data with `dal_oe`=1 from tick 4 to the last tick of the cycle, which covers two ticks after `das_n` rises.
- R8: `ready_n` is sampled only at the last strobe tick (tick 9+2k). Each sample that finds it high adds two ticks of `das_n`=0. With k high samples, `das_n` is 0 in ticks 5 to 9+2k and the cycle lasts 12+2k ticks.
- R9: `word_done` is a one-tick pulse in the last tick of each cycle. On a read, `rd_data` then holds the `dal_in` value sampled with READY.
- R10: After each cycle one gap tick follows. If `req_valid` is high and fewer than 8 words were moved in this tenure, the next cycle starts. Otherwise the bus is released: `bus_req_n`=1, `ctl_oe`=0.
- R11: After a release, a new request is raised only once `bus_gnt_n` has been seen high.
- R12: `rd_wr` is 1 for a read and 0 for a write throughout a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per period |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A word is waiting to be moved |
| req_write | input | 1 | 1 = write the word, 0 = read it |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| as_active_high | input | 1 | Latch strobe polarity select |
| bus_req_n | output | 1 | Active-low bus request |
| bus_gnt_n | input | 1 | Active-low bus grant |
| ready_n | input | 1 | Active-low slave READY |
| dal_out | output | 16 | Shared address/data lines, driven value |
| dal_oe | output | 1 | Drive enable for `dal_out` |
| dal_in | input | 16 | Shared lines as read back |
| ctl_oe | output | 1 | Drive enable for strobes, `rd_wr` and `xcvr_rd_n` |
| ale | output | 1 | Address latch strobe, level set by `as_active_high` |
| das_n | output | 1 | Active-low data strobe |
| rd_wr | output | 1 | 1 = read cycle |
| xcvr_rd_n | output | 1 | Active-low transceiver direction: bus into block |
| word_done | output | 1 | One-tick pulse per finished word |
| rd_data | output | 16 | Read data of the last finished read |

## Verification
The bench sees the grant at one falling edge and expects tick 0 of the cycle at the next falling edge. From there it checks every output at every tick of the cycle against a timeline it computes from the wait count k that it chose for the slave. The bench drives READY low only in tick 9+2k and changes `dal_in` on every other tick. So `rd_data` is correct at the `word_done` tick only if it was captured in that exact tick. It samples the gap tick one tick after the cycle ends, and the release or the next address phase one tick after that. It also holds the grant low for one tick after a release, to show that no new request is raised before the grant goes high.

// File: rtl/bus_master_seq.sv
module bus_master_seq #(
  parameter int DW        = 16,
  parameter int MAX_BURST = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          as_active_high,
  output logic          bus_req_n,
  input  logic          bus_gnt_n,
  input  logic          ready_n,
  output logic [DW-1:0] dal_out,
  output logic          dal_oe,
  input  logic [DW-1:0] dal_in,
  output logic          ctl_oe,
  output logic          ale,
  output logic          das_n,
  output logic          rd_wr,
  output logic          xcvr_rd_n,
  output logic          word_done,
  output logic [DW-1:0] rd_data
);
  localparam int CNT_W = $clog2(MAX_BURST + 1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_BURST);
  localparam logic [3:0] P_ALE  = 4'd2;
  localparam logic [3:0] P_TURN = 4'd4;
  localparam logic [3:0] P_DAS  = 4'd5;
  localparam logic [3:0] P_CHK  = 4'd9;
  localparam logic [3:0] P_LAST = 4'd11;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_CYC, S_GAP} st_t;

  st_t             st;
  logic [3:0]      ph;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]   cur_addr, cur_wdata;
  logic            cur_wr;
  logic            start, cyc, strobe;

  assign cyc   = (st == S_CYC);
  assign start = ((st == S_REQ) && !bus_gnt_n) ||
                 ((st == S_GAP) && req_valid && (cnt < CAP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= '0;
      cnt <= '0;
      rd_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid && bus_gnt_n) st <= S_REQ;
        S_REQ: if (!bus_gnt_n) begin
          st  <= S_CYC;
          ph  <= '0;
          cnt <= '0;
        end
        S_CYC: begin
          if (ph == P_CHK && ready_n) ph <= P_CHK - 4'd1;
          else if (ph == P_LAST) begin
            st  <= S_GAP;
            cnt <= cnt + CNT_W'(1);
          end else ph <= ph + 4'd1;
          if (ph == P_CHK && !ready_n && !cur_wr) rd_data <= dal_in;
        end
        default: begin
          ph <= '0;
          st <= start ? S_CYC : S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_wr    <= 1'b0;
    end else if (start) begin
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
      cur_wr    <= req_write;
    end
  end

  assign strobe    = cyc && (ph < P_ALE);
  assign ale       = as_active_high ? strobe : !strobe;
  assign das_n     = !(cyc && ph >= P_DAS && ph <= P_CHK);
  assign dal_oe    = cyc && ((ph < P_TURN) || cur_wr);
  assign dal_out   = (ph < P_TURN) ? cur_addr : cur_wdata;
  assign ctl_oe    = cyc || (st == S_GAP);
  assign bus_req_n = !(ctl_oe || (st == S_REQ));
  assign rd_wr     = !cur_wr;
  assign xcvr_rd_n = !(cyc && !cur_wr && ph >= P_TURN);
  assign word_done = cyc && (ph == P_LAST);
endmodule

module bus_master_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req_n,
  input logic ctl_oe,
  input logic dal_oe,
  input logic ale,
  input logic as_active_high,
  input logic das_n,
  input logic rd_wr,
  input logic word_done
);
  logic strobe;
  assign strobe = ctl_oe && (as_active_high ? ale : !ale);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_n |-> (!ctl_oe && !dal_oe));
  p_owner_requests_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_oe |-> !bus_req_n);
  p_strobes_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> das_n);
  p_strobe_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |=> strobe);
  p_read_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && !das_n && rd_wr) |-> !dal_oe);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);
  p_gap_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !bus_req_n);
endmodule

bind bus_master_seq bus_master_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .ctl_oe(ctl_oe),
  .dal_oe(dal_oe), .ale(ale), .as_active_high(as_active_high),
  .das_n(das_n), .rd_wr(rd_wr), .word_done(word_done)
);

// File: tb/bus_master_seq_test.sv
module bus_master_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_write, as_active_high, bus_gnt_n, ready_n;
  logic [15:0] req_addr, req_wdata, dal_in, dal_out, rd_data;
  logic bus_req_n, dal_oe, ctl_oe, ale, das_n, rd_wr, xcvr_rd_n, word_done;

  bus_master_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .as_active_high(as_active_high),
    .bus_req_n(bus_req_n), .bus_gnt_n(bus_gnt_n), .ready_n(ready_n),
    .dal_out(dal_out), .dal_oe(dal_oe), .dal_in(dal_in), .ctl_oe(ctl_oe),
    .ale(ale), .das_n(das_n), .rd_wr(rd_wr), .xcvr_rd_n(xcvr_rd_n),
    .word_done(word_done), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic chkb(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chkw(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic ale_level(input logic pol, input int t);
    return pol ? (t < 2) : !(t < 2);
  endfunction

  function automatic logic das_level(input int t, input int k);
    return !(t >= 5 && t <= 9 + 2 * k);
  endfunction

  // entered at the falling edge of tick 0; leaves at the falling edge of the gap tick
  task automatic run_word(input logic [15:0] a, input logic [15:0] wd, input logic wr,
                          input int k, input logic [15:0] rv, input logic pol,
                          input logic nv, input logic [15:0] na,
                          input logic [15:0] nwd, input logic nwr);
    int last;
    last = 11 + 2 * k;
    for (int t = 0; t <= last; t++) begin
      chkb("R5 ale level", ale, ale_level(pol, t));
      chkb("R4/R6 dal_oe", dal_oe, (t < 4) ? 1'b1 : wr);
      if (t < 4) chkw("R4 address", dal_out, a);
      else if (wr) chkw("R7 write data", dal_out, wd);
      chkb("R8 das_n", das_n, das_level(t, k));
      chkb("R12 rd_wr", rd_wr, !wr);
      chkb("R6 xcvr_rd_n", xcvr_rd_n, !(!wr && t >= 4));
      chkb("R9 word_done", word_done, t == last);
      if (t == last && !wr) chkw("R9 rd_data", rd_data, rv);
      chkb("R3 bus_req_n", bus_req_n, 1'b0);
      chkb("R3 ctl_oe", ctl_oe, 1'b1);
      if (t == 9 + 2 * k) begin
        ready_n = 1'b0;
        dal_in  = rv;
      end else begin
        ready_n = 1'b1;
        dal_in  = 16'($urandom);
      end
      if (t == last) begin
        req_valid = nv;
        req_addr  = na;
        req_wdata = nwd;
        req_write = nwr;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_burst(input int n, input logic pol, input int gd, input int kmax);
    logic [15:0] a[17], wd[17], rv[17];
    logic        wr[17];
    int          k[17];
    int          done, tenure;
    for (int i = 0; i < 17; i++) begin
      a[i] = 16'($urandom); wd[i] = 16'($urandom); rv[i] = 16'($urandom);
      wr[i] = 1'($urandom); k[i] = int'($urandom_range(kmax, 0));
    end
    as_active_high = pol;
    req_valid = 1'b1; req_addr = a[0]; req_wdata = wd[0]; req_write = wr[0];
    done = 0;
    while (done < n) begin
      @(negedge clk);
      chkb("R2 request raised", bus_req_n, 1'b0);
      for (int g = 0; g < gd; g++) begin
        chkb("R2 no drive before grant", ctl_oe, 1'b0);
        chkb("R2 no data before grant", dal_oe, 1'b0);
        @(negedge clk);
      end
      chkb("R2 no drive before grant", ctl_oe, 1'b0);
      bus_gnt_n = 1'b0;
      @(negedge clk);
      tenure = 0;
      forever begin
        run_word(a[done], wd[done], wr[done], k[done], rv[done], pol,
                 done + 1 < n, a[done + 1], wd[done + 1], wr[done + 1]);
        done++; tenure++;
        chkb("R3 gap bus_req_n", bus_req_n, 1'b0);
        chkb("R10 gap ctl_oe", ctl_oe, 1'b1);
        chkb("R10 gap dal_oe", dal_oe, 1'b0);
        @(negedge clk);
        if (done < n && tenure < 8) begin
          chkb("R10 next cycle starts", ale, ale_level(pol, 0));
        end else begin
          chkb("R10 release bus_req_n", bus_req_n, 1'b1);
          chkb("R10 release ctl_oe", ctl_oe, 1'b0);
          @(negedge clk);
          chkb("R11 no request while granted", bus_req_n, 1'b1);
          bus_gnt_n = 1'b1;
          break;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    as_active_high = 1'b1; bus_gnt_n = 1'b1; ready_n = 1'b1; dal_in = '0;
    repeat (3) @(negedge clk);
    chkb("R1 reset bus_req_n", bus_req_n, 1'b1);
    chkb("R1 reset ctl_oe", ctl_oe, 1'b0);
    chkb("R1 reset dal_oe", dal_oe, 1'b0);
    chkb("R1 reset word_done", word_done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chkb("R1 idle bus_req_n", bus_req_n, 1'b1);
    chkb("R1 idle ctl_oe", ctl_oe, 1'b0);
    run_burst(1, 1'b1, 0, 0);
    run_burst(8, 1'b0, 2, 0);
    run_burst(11, 1'b1, 1, 2);
    run_burst(3, 1'b0, 3, 4);
    run_burst(16, 1'b1, 0, 1);
    for (int b = 0; b < 20; b++)
      run_burst(int'($urandom_range(12, 1)), 1'($urandom),
                int'($urandom_range(3, 0)), int'($urandom_range(3, 0)));
    repeat (2) @(negedge clk);
    chkb("R1 final idle", bus_req_n, 1'b1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule